// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned binary words and drives three mutually exclusive result lines: first operand greater, operands equal, first operand less. It is purely combinational. It has no clock and no storage.

The word is cut into fixed-width slices, four bits each by default. Each slice is handled by one comparator stage. A stage looks at its bit pairs from the top bit downward, and the highest bit position where the operands differ decides that stage's answer. When every bit pair in the slice matches, the stage has no opinion of its own. It then forwards the verdict it received on its three cascade inputs from the stage below.

The stages are chained from the least significant slice upward, and the top stage's outputs form the final result. The chain's own cascade inputs feed the lowest stage. For a plain comparison they are driven with equal high and greater/less low. The default configuration chains two stages into an 8-bit comparator.

Top module: `mag_cmp_chain`

## Requirements
- R1: A stage compares its slice of aWord and bWord as unsigned numbers. When the top slices of the chain differ, aGreater is high exactly when the top slice of aWord is numerically larger, and aLess is high exactly when it is smaller.
- R2: Inside a slice, the highest bit position where the operands differ fixes the result, whatever lower bits or cascade inputs say. For example, aWord=0x80 with bWord=0x7F gives aGreater=1, aEqual=0, aLess=0.
- R3: aEqual is high only when every bit of aWord equals the matching bit of bWord and casEq is high. With both words zero and casEq=1, aEqual=1 and the other two outputs are 0.
- R4: When aWord equals bWord, the outputs copy the chain's cascade inputs: aGreater=casGt, aEqual=casEq, aLess=casLt.
- R5: Whenever exactly one of casGt, casEq, casLt is high, exactly one of aGreater, aEqual, aLess is high.
- R6: Stage k compares bits [4k+3:4k]. Its cascade inputs are the outputs of stage k-1, and stage 0 takes casGt/casEq/casLt. When the upper slices tie, the result of a lower slice passes up to the outputs.
- R7: With casEq=1 and casGt=casLt=0, the three outputs match an integer compare of aWord against bWord for all 65536 operand pairs of the default 8-bit chain.
- R8: aWord=0x06 with bWord=0x03 and casEq=1 gives aGreater=1, aEqual=0, aLess=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aWord | input | WIDTH (8) | First unsigned operand |
| bWord | input | WIDTH (8) | Second unsigned operand |
| casGt | input | 1 | Cascade-in: lower-order result says greater |
| casEq | input | 1 | Cascade-in: lower-order result says equal |
| casLt | input | 1 | Cascade-in: lower-order result says less |
| aGreater | output | 1 | aWord is greater than bWord |
| aEqual | output | 1 | aWord equals bWord, and the cascade says equal |
| aLess | output | 1 | aWord is less than bWord |

## Verification
Four properties are checked inside every stage on each evaluation:
- exactly one of the slice's differ/tie strobes is set;
- a stage's outputs stay one-hot whenever its cascade inputs are one-hot;
- a tied slice forwards its cascade verdict unchanged;
- a stage's equal output implies equal slices and a high cascade-equal.

A strict numeric inequality between the slices forcing the matching output is also checked. What the assertions cannot show is that the stages are joined in the right order with the right bit slices. That is shown only by the bench, which sweeps all operand pairs and also drives the tie and precedence cases with non-default cascade inputs.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // three-line verdict carried between stages
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpRes_t;

  // strobes raised by a slice datapath toward the resolver
  typedef struct packed {
    logic aHi;   // first differing bit (from top) has a=1, b=0
    logic bHi;   // first differing bit (from top) has a=0, b=1
    logic tie;   // every bit pair of the slice matches
  } cmpStrobe_t;

endpackage

// File: rtl/mag_cmp_slice_dp.sv
module mag_cmp_slice_dp
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_BITS = 4
) (
  input  logic [SLICE_BITS-1:0] aSlice,
  input  logic [SLICE_BITS-1:0] bSlice,
  output cmpStrobe_t            strobes
);

  localparam int TOP = SLICE_BITS - 1;

  logic [SLICE_BITS-1:0] bitSame;     // XNOR of each pair
  logic [SLICE_BITS-1:0] aOnly;       // a=1, b=0 at this position
  logic [SLICE_BITS-1:0] bOnly;       // a=0, b=1 at this position
  logic [SLICE_BITS-1:0] aboveSame;   // all higher positions match

  assign aboveSame[TOP] = 1'b1;

  for (genvar i = 0; i < SLICE_BITS; i++) begin : g_bit
    assign bitSame[i] = ~(aSlice[i] ^ bSlice[i]);
    assign aOnly[i]   = aSlice[i] & ~bSlice[i];
    assign bOnly[i]   = ~aSlice[i] & bSlice[i];
    if (i < TOP) begin : g_chain
      assign aboveSame[i] = aboveSame[i+1] & bitSame[i+1];
    end
  end

  assign strobes.aHi = |(aOnly & aboveSame);
  assign strobes.bHi = |(bOnly & aboveSame);
  assign strobes.tie = &bitSame;

  // R2: exactly one strobe for any known operand pair
  always_comb begin
    if (!$isunknown({aSlice, bSlice})) begin
      p_strobe_exclusive_r2: assert ($countones({strobes.aHi, strobes.bHi, strobes.tie}) == 1)
        else $error("slice strobes not exclusive");
    end
  end

endmodule

// File: rtl/mag_cmp_resolve.sv
module mag_cmp_resolve
  import mag_cmp_pkg::*;
(
  input  cmpStrobe_t strobes,
  input  cmpRes_t    casIn,
  output cmpRes_t    resOut
);

  always_comb begin
    resOut.gt = strobes.aHi | (strobes.tie & casIn.gt);
    resOut.lt = strobes.bHi | (strobes.tie & casIn.lt);
    resOut.eq = strobes.tie & casIn.eq;
  end

endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_BITS = 4
) (
  input  logic [SLICE_BITS-1:0] aSlice,
  input  logic [SLICE_BITS-1:0] bSlice,
  input  cmpRes_t               casIn,
  output cmpRes_t               resOut
);

  cmpStrobe_t strobes;

  mag_cmp_slice_dp #(.SLICE_BITS(SLICE_BITS)) u_dp (
    .aSlice (aSlice),
    .bSlice (bSlice),
    .strobes(strobes)
  );

  mag_cmp_resolve u_ctl (
    .strobes(strobes),
    .casIn  (casIn),
    .resOut (resOut)
  );

  always_comb begin
    if (!$isunknown({aSlice, bSlice, casIn, resOut})) begin
      // R1: strict numeric order of the slice forces the matching line
      if (aSlice > bSlice) begin
        p_gt_forced_r1: assert (resOut.gt && !resOut.eq && !resOut.lt)
          else $error("greater slice not reported");
      end
      if (aSlice < bSlice) begin
        p_lt_forced_r1: assert (resOut.lt && !resOut.eq && !resOut.gt)
          else $error("smaller slice not reported");
      end
      // R4: a tied slice forwards the cascade verdict
      if (aSlice == bSlice) begin
        p_tie_forward_r4: assert (resOut == casIn)
          else $error("tie did not forward cascade");
      end
      // R3: equal out implies equal slice and cascade-equal
      if (resOut.eq) begin
        p_eq_needs_all_r3: assert (aSlice == bSlice && casIn.eq)
          else $error("equal raised without full match");
      end
      // R5: one-hot in, one-hot out
      if ($onehot(casIn)) begin
        p_onehot_out_r5: assert ($onehot(resOut))
          else $error("stage outputs not one-hot");
      end
    end
  end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int STAGE_BITS = 4,
  parameter int NUM_STAGES = 2,
  localparam int WIDTH = STAGE_BITS * NUM_STAGES
) (
  input  logic [WIDTH-1:0] aWord,
  input  logic [WIDTH-1:0] bWord,
  input  logic             casGt,
  input  logic             casEq,
  input  logic             casLt,
  output logic             aGreater,
  output logic             aEqual,
  output logic             aLess
);

  // link[k] feeds stage k; link[NUM_STAGES] is the final verdict (R6)
  cmpRes_t link [NUM_STAGES+1];

  assign link[0] = '{gt: casGt, eq: casEq, lt: casLt};

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    mag_cmp_stage #(.SLICE_BITS(STAGE_BITS)) u_stage (
      .aSlice(aWord[k*STAGE_BITS +: STAGE_BITS]),
      .bSlice(bWord[k*STAGE_BITS +: STAGE_BITS]),
      .casIn (link[k]),
      .resOut(link[k+1])
    );
  end

  assign aGreater = link[NUM_STAGES].gt;
  assign aEqual   = link[NUM_STAGES].eq;
  assign aLess    = link[NUM_STAGES].lt;

endmodule

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aWord, bWord;
  logic casGt, casEq, casLt;
  logic aGreater, aEqual, aLess;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mag_cmp_chain u_dut (
    .aWord(aWord), .bWord(bWord),
    .casGt(casGt), .casEq(casEq), .casLt(casLt),
    .aGreater(aGreater), .aEqual(aEqual), .aLess(aLess)
  );

  // behavioural reference: integer order, cascade only on a tie
  task automatic apply(input int a, input int b, input bit cg, input bit ce,
                       input bit cl, input string tag);
    int ea, eq, el;
    @(negedge clk);
    aWord = W'(a); bWord = W'(b);
    casGt = cg; casEq = ce; casLt = cl;
    if (a > b)      begin ea = 1; eq = 0;  el = 0;  end
    else if (a < b) begin ea = 0; eq = 0;  el = 1;  end
    else            begin ea = cg; eq = ce; el = cl; end
    @(posedge clk);
    #1;
    nChecks++;
    if ({aGreater, aEqual, aLess} !== {ea[0], eq[0], el[0]}) begin
      nFails++;
      $display("FAIL %s a=%02h b=%02h cas=%b%b%b actual=%b%b%b expected=%0d%0d%0d",
               tag, a, b, cg, ce, cl, aGreater, aEqual, aLess, ea, eq, el);
    end
    if ($onehot({cg, ce, cl})) begin
      nChecks++;
      if (!$onehot({aGreater, aEqual, aLess})) begin
        nFails++;
        $display("FAIL R5 a=%02h b=%02h actual=%b%b%b expected=one-hot",
                 a, b, aGreater, aEqual, aLess);
      end
    end
  endtask

  initial begin
    aWord = '0; bWord = '0; casGt = 0; casEq = 1; casLt = 0;
    repeat (3) @(posedge clk);
    // R3: reset-time state, zero operands with cascade-equal
    apply(0, 0, 0, 1, 0, "R3");
    rst = 1'b0;
    // R8: worked example
    apply(8'h06, 8'h03, 0, 1, 0, "R8");
    // R2: top bit decides against all-ones below, cascade ignored
    apply(8'h80, 8'h7F, 0, 0, 1, "R2");
    apply(8'h7F, 8'h80, 1, 0, 0, "R2");
    apply(8'h0B, 8'h04, 0, 0, 1, "R2");
    // R4: ties pass every one-hot and a non-one-hot cascade
    apply(8'h5A, 8'h5A, 1, 0, 0, "R4");
    apply(8'h5A, 8'h5A, 0, 0, 1, "R4");
    apply(8'hFF, 8'hFF, 0, 1, 0, "R4");
    apply(8'h00, 8'h00, 1, 0, 1, "R4");
    apply(8'h33, 8'h33, 0, 0, 0, "R4");
    // R3: equal needs casEq
    apply(8'hC3, 8'hC3, 0, 0, 0, "R3");
    // R6: upper slices tie, lower slice result passes upward
    apply(8'h92, 8'h97, 1, 0, 0, "R6");
    apply(8'h9E, 8'h91, 0, 0, 1, "R6");
    // R1/R6/R4/R7: full sweep with default cascade
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        if (a == b)                   apply(a, b, 0, 1, 0, "R7/R4");
        else if ((a >> 4) != (b >> 4)) apply(a, b, 0, 1, 0, "R7/R1");
        else                          apply(a, b, 0, 1, 0, "R7/R6");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule